// File: doc/BRIEF.md
# AXI4-Lite Link Tunnel Requester

This block lives on the control-board end of a board-to-board link. It takes AXI4-Lite reads and writes on a slave port and turns each one into a single request payload for a link frame transmitter. It then waits for the matching response payload from the frame receiver and returns it on the B or R channel. Both payload ports use a plain valid/ready handshake. Serialisation, framing, CRC and the physical link are handled elsewhere.

Only one transaction can be open at a time. A round trip across the link takes many frame periods, and its length varies. A cycle-count watchdog therefore turns a missing reply into a local SLVERR completion, so the bus never stalls. A reply that reports a far-side timeout is also returned as SLVERR.

The controller has five states:
- ST_IDLE: nothing captured.
- ST_HALF: one of AW or W accepted.
- ST_SEND: request payload offered.
- ST_WAIT: watchdog running.
- ST_RESP: B or R valid.

The transitions are:
- ST_IDLE to ST_SEND: on an AR handshake, or on AW and W together.
- ST_IDLE to ST_HALF: on only one of AW or W.
- ST_HALF to ST_SEND: when the missing half arrives.
- ST_SEND to ST_WAIT: when the transmitter takes the payload.
- ST_WAIT to ST_RESP: when a reply arrives or the watchdog expires.
- ST_RESP to ST_IDLE: on the B or R handshake.

Top module: `axil_tunnel_req`

## Requirements
- R1: After both AW and W are accepted, exactly one request payload is offered with these fields:
  - bit 68 = 1 (write).
  - bits 67:36 = address.
  - bits 35:4 = write data.
  - bits 3:0 = strobe.
- R2: After AR is accepted, a request payload is offered with these fields:
  - bit 68 = 0 (read).
  - bits 67:36 = address.
  - bits 35:0 = zero.
- R3: AW and W may be accepted in the same cycle or in either order. The request is offered only once both have been accepted.
- R4: From the first accepted request part until the B or R handshake completes, awready, wready and arready are low, except for the still-missing half of a write.
- R5: For a write, BRESP equals bits 34:33 of the response payload. The payload layout is:
  - bit 35 = read/write.
  - bits 34:33 = response code.
  - bits 32:1 = read data.
  - bit 0 = far-side timeout flag.
- R6: For a read, RRESP equals payload bits 34:33 and RDATA equals payload bits 32:1.
- R7: A response payload with bit 0 set completes the transaction with code 2'b10 (SLVERR), and RDATA is zero on reads.
- R8: If no response is accepted within TIMEOUT_CYC cycles of the request handshake, B or R becomes valid with code 2'b10 (SLVERR) and RDATA zero. This happens on the cycle after the TIMEOUT_CYC-th clock edge.
- R9: A response payload that arrives while no reply is awaited (after a timeout, or when idle) is consumed and dropped. It produces no B or R beat and does not change the next transaction's result.
- R10: While the request payload is valid and not ready, the payload stays unchanged. B or R stays valid with a stable code until it is accepted.
- R11: After reset, req_valid, s_bvalid and s_rvalid are low and s_awready is high.
- R12: When AW/W and AR are presented in the same cycle, the write is accepted first. The read is accepted only after the write completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | 32 | Write address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | 32 | Read address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| req_valid | output | 1 | Request payload valid toward the frame transmitter |
| req_ready | input | 1 | Frame transmitter accepts the payload |
| req_payload | output | 69 | Request payload |
| rsp_valid | input | 1 | Response payload valid from the frame receiver |
| rsp_ready | output | 1 | Response payload accepted (always high) |
| rsp_payload | input | 36 | Response payload |

## Verification
The hardest situation to reach from the ports is a reply that arrives after the watchdog has already completed the transaction. It must vanish without a trace, while the next transaction still takes its own reply. The bench builds this directly: it withholds the response until SLVERR appears, injects a stray reply while B is pending, injects another while the block is idle, and then runs a read with a distinct reply. The watchdog edge itself is checked by counting cycles from the request handshake to the error beat. The random phase also withholds replies at random, among random orderings of AW and W.

// File: rtl/tun_pkg.sv
package tun_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int STRB_W = DATA_W / 8;
    localparam int REQ_W  = 1 + ADDR_W + DATA_W + STRB_W;
    localparam int RSP_W  = 1 + 2 + DATA_W + 1;
    localparam logic [1:0] RESP_SLVERR = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HALF,
        ST_SEND,
        ST_WAIT,
        ST_RESP
    } tun_state_t;
endpackage

// File: rtl/tun_capture.sv
module tun_capture
    import tun_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aw_hs,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              w_hs,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    input  logic              ar_hs,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              clr,
    output logic              aw_got,
    output logic              w_got,
    output logic              is_write,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data,
    output logic [STRB_W-1:0] strb
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aw_got   <= 1'b0;
            w_got    <= 1'b0;
            is_write <= 1'b0;
            addr     <= '0;
            data     <= '0;
            strb     <= '0;
        end else begin
            if (clr) begin
                aw_got <= 1'b0;
                w_got  <= 1'b0;
            end
            if (ar_hs) begin
                is_write <= 1'b0;
                addr     <= araddr;
                data     <= '0;
                strb     <= '0;
            end
            if (aw_hs) begin
                is_write <= 1'b1;
                addr     <= awaddr;
                aw_got   <= 1'b1;
            end
            if (w_hs) begin
                data  <= wdata;
                strb  <= wstrb;
                w_got <= 1'b1;
            end
        end
    end

    // R4
    no_read_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ar_hs |-> !aw_hs && !w_hs && !aw_got && !w_got);
endmodule

// File: rtl/tun_wdog.sv
module tun_wdog #(
    parameter int LIMIT = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic fire
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign fire = run && (cnt == LAST);

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/axil_tunnel_req.sv
module axil_tunnel_req
    import tun_pkg::*;
#(
    parameter int TIMEOUT_CYC = 125000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_wvalid,
    output logic              s_wready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [STRB_W-1:0] s_wstrb,
    output logic              s_bvalid,
    input  logic              s_bready,
    output logic [1:0]        s_bresp,
    input  logic              s_arvalid,
    output logic              s_arready,
    input  logic [ADDR_W-1:0] s_araddr,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [REQ_W-1:0]  req_payload,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [RSP_W-1:0]  rsp_payload
);
    tun_state_t state, state_nx;

    logic              aw_hs, w_hs, ar_hs, req_hs;
    logic              aw_got, w_got, is_write;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;
    logic [STRB_W-1:0] cap_strb;
    logic              wd_fire;
    logic [1:0]        ret_code;
    logic [DATA_W-1:0] ret_data;
    logic              rsp_dir_unused;

    wire               rsp_far_tmo = rsp_payload[0];
    wire [DATA_W-1:0]  rsp_rdata   = rsp_payload[DATA_W:1];
    wire [1:0]         rsp_code    = rsp_payload[DATA_W+2:DATA_W+1];

    assign rsp_dir_unused = rsp_payload[RSP_W-1];
    assign aw_hs  = s_awvalid && s_awready;
    assign w_hs   = s_wvalid  && s_wready;
    assign ar_hs  = s_arvalid && s_arready;
    assign req_hs = req_valid && req_ready;

    tun_capture cap_i (
        .clk(clk), .rst_n(rst_n),
        .aw_hs(aw_hs), .awaddr(s_awaddr),
        .w_hs(w_hs), .wdata(s_wdata), .wstrb(s_wstrb),
        .ar_hs(ar_hs), .araddr(s_araddr),
        .clr(req_hs),
        .aw_got(aw_got), .w_got(w_got), .is_write(is_write),
        .addr(cap_addr), .data(cap_data), .strb(cap_strb)
    );

    tun_wdog #(.LIMIT(TIMEOUT_CYC)) wdog_i (
        .clk(clk), .rst_n(rst_n),
        .run(state == ST_WAIT),
        .fire(wd_fire)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (ar_hs)                state_nx = ST_SEND;
                else if (aw_hs && w_hs)   state_nx = ST_SEND;
                else if (aw_hs || w_hs)   state_nx = ST_HALF;
            end
            ST_HALF: if ((aw_got || aw_hs) && (w_got || w_hs)) state_nx = ST_SEND;
            ST_SEND: if (req_ready) state_nx = ST_WAIT;
            ST_WAIT: if (rsp_valid || wd_fire) state_nx = ST_RESP;
            ST_RESP: if (is_write ? s_bready : s_rready) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        s_awready = 1'b0;
        s_wready  = 1'b0;
        s_arready = 1'b0;
        req_valid = 1'b0;
        s_bvalid  = 1'b0;
        s_rvalid  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                s_awready = 1'b1;
                s_wready  = 1'b1;
                s_arready = !s_awvalid && !s_wvalid;
            end
            ST_HALF: begin
                s_awready = !aw_got;
                s_wready  = !w_got;
            end
            ST_SEND: req_valid = 1'b1;
            ST_WAIT: ;
            ST_RESP: begin
                s_bvalid = is_write;
                s_rvalid = !is_write;
            end
            default: ;
        endcase
    end

    assign rsp_ready   = 1'b1;
    assign req_payload = {is_write, cap_addr, cap_data, cap_strb};
    assign s_bresp     = ret_code;
    assign s_rresp     = ret_code;
    assign s_rdata     = ret_data;

    // returned response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_code <= '0;
            ret_data <= '0;
        end else if (state == ST_WAIT) begin
            if (rsp_valid) begin
                ret_code <= rsp_far_tmo ? RESP_SLVERR : rsp_code;
                ret_data <= rsp_far_tmo ? '0 : rsp_rdata;
            end else if (wd_fire) begin
                ret_code <= RESP_SLVERR;
                ret_data <= '0;
            end
        end
    end

    // R4
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid || s_bvalid || s_rvalid) |-> !s_awready && !s_wready && !s_arready);
    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_payload));
    // R10
    b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid && !s_bready |=> s_bvalid && $stable(s_bresp));
    // R10
    r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid && !s_rready |=> s_rvalid && $stable(s_rresp) && $stable(s_rdata));
    // R8
    wdog_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_fire && !rsp_valid |=> (s_bvalid || s_rvalid) && s_bresp == RESP_SLVERR && s_rdata == '0);
    // R7
    far_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_WAIT && rsp_valid && rsp_far_tmo |=> s_bresp == RESP_SLVERR && s_rdata == '0);
    // R5
    one_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_bvalid && s_rvalid));
endmodule

// File: tb/axil_tunnel_req_tb_top.sv
`timescale 1ns/1ps
module axil_tunnel_req_tb_top;
    import tun_pkg::*;

    localparam int TMO = 48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic              s_awvalid = 0, s_wvalid = 0, s_arvalid = 0;
    logic              s_bready = 0, s_rready = 0, req_ready = 0, rsp_valid = 0;
    logic [ADDR_W-1:0] s_awaddr = 0, s_araddr = 0;
    logic [DATA_W-1:0] s_wdata = 0;
    logic [STRB_W-1:0] s_wstrb = 0;
    logic [RSP_W-1:0]  rsp_payload = 0;
    logic              s_awready, s_wready, s_arready, s_bvalid, s_rvalid;
    logic              req_valid, rsp_ready;
    logic [1:0]        s_bresp, s_rresp;
    logic [DATA_W-1:0] s_rdata;
    logic [REQ_W-1:0]  req_payload;

    int total = 0;
    int bad = 0;

    axil_tunnel_req #(.TIMEOUT_CYC(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
        .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
        .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
        .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
        .req_valid(req_valid), .req_ready(req_ready), .req_payload(req_payload),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_payload(rsp_payload)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [REQ_W-1:0] exp_req(input logic w, input logic [31:0] a,
                                                 input logic [31:0] d, input logic [3:0] s);
        return w ? {1'b1, a, d, s} : {1'b0, a, 36'd0};
    endfunction

    function automatic logic [1:0] exp_code(input logic [1:0] c, input logic far);
        return far ? 2'b10 : c;
    endfunction

    function automatic logic [31:0] exp_data(input logic w, input logic [31:0] d, input logic far);
        return (w || far) ? 32'd0 : d;
    endfunction

    task automatic drive_aw(input logic [31:0] a);
        @(negedge clk); s_awvalid = 1; s_awaddr = a; #1;
        while (!s_awready) begin @(negedge clk); #1; end
        @(posedge clk); @(negedge clk); s_awvalid = 0;
    endtask

    task automatic drive_w(input logic [31:0] d, input logic [3:0] s);
        @(negedge clk); s_wvalid = 1; s_wdata = d; s_wstrb = s; #1;
        while (!s_wready) begin @(negedge clk); #1; end
        @(posedge clk); @(negedge clk); s_wvalid = 0;
    endtask

    task automatic drive_ar(input logic [31:0] a);
        @(negedge clk); s_arvalid = 1; s_araddr = a; #1;
        while (!s_arready) begin @(negedge clk); #1; end
        @(posedge clk); @(negedge clk); s_arvalid = 0;
    endtask

    task automatic drive_write(input int order, input logic [31:0] a,
                               input logic [31:0] d, input logic [3:0] s);
        if (order == 0) begin
            @(negedge clk); s_awvalid = 1; s_awaddr = a; s_wvalid = 1; s_wdata = d; s_wstrb = s; #1;
            while (!(s_awready && s_wready)) begin @(negedge clk); #1; end
            @(posedge clk); @(negedge clk); s_awvalid = 0; s_wvalid = 0;
        end else if (order == 1) begin
            drive_aw(a);
            #1; chk("R3 no request after AW only", {127'd0, req_valid}, 128'd0);
            drive_w(d, s);
        end else begin
            drive_w(d, s);
            #1; chk("R3 no request after W only", {127'd0, req_valid}, 128'd0);
            drive_aw(a);
        end
    endtask

    task automatic serve_req(input logic [REQ_W-1:0] exp, input int hold, input string tag);
        logic stable_ok = 1;
        #1;
        while (!req_valid) begin @(negedge clk); #1; end
        chk(tag, {59'd0, req_payload}, {59'd0, exp});
        for (int i = 0; i < hold; i++) begin
            @(negedge clk); #1;
            if (!req_valid || req_payload !== exp) stable_ok = 0;
        end
        if (hold > 0) chk("R10 request held while not ready", {127'd0, stable_ok}, 128'd1);
        @(negedge clk); req_ready = 1;
        @(posedge clk); @(negedge clk); req_ready = 0; #1;
    endtask

    task automatic send_rsp(input logic [RSP_W-1:0] p, input int dly);
        repeat (dly) @(negedge clk);
        @(negedge clk); rsp_valid = 1; rsp_payload = p;
        @(posedge clk); @(negedge clk); rsp_valid = 0; rsp_payload = '0;
    endtask

    task automatic take_resp(input logic w, input logic [1:0] ec, input logic [31:0] ed,
                             input int bdly, input string tag);
        logic busy_ok = 1;
        #1;
        while (!(w ? s_bvalid : s_rvalid)) begin
            if (s_awready || s_wready || s_arready) busy_ok = 0;
            @(negedge clk); #1;
        end
        chk("R4 no readies while busy", {127'd0, busy_ok}, 128'd1);
        for (int i = 0; i < bdly; i++) begin @(negedge clk); #1; end
        if (w) chk(tag, {126'd0, s_bresp}, {126'd0, ec});
        else   chk(tag, {94'd0, s_rresp, s_rdata}, {94'd0, ec, ed});
        @(negedge clk); if (w) s_bready = 1; else s_rready = 1;
        @(posedge clk); @(negedge clk); s_bready = 0; s_rready = 0;
    endtask

    task automatic random_txn();
        logic        w    = 1'($urandom % 2);
        logic [31:0] a    = $urandom;
        logic [31:0] d    = $urandom;
        logic [3:0]  s    = 4'($urandom);
        logic [1:0]  c    = 2'($urandom);
        logic [31:0] rd   = $urandom;
        logic        far  = ($urandom % 6) == 0;
        logic        tmo  = ($urandom % 10) == 0;
        int          order = int'($urandom % 3);
        int          dly   = int'($urandom % (TMO - 10));
        int          hold  = int'($urandom % 3);
        int          bdly  = int'($urandom % 3);
        if (w) drive_write(order, a, d, s); else drive_ar(a);
        serve_req(exp_req(w, a, d, s), hold, w ? "R1 write request payload" : "R2 read request payload");
        if (tmo) begin
            take_resp(w, 2'b10, 32'd0, bdly, "R8 random timeout SLVERR");
        end else begin
            send_rsp({w, c, rd, far}, dly);
            take_resp(w, exp_code(c, far), exp_data(w, rd, far), bdly,
                      far ? "R7 far timeout flag" : (w ? "R5 write response" : "R6 read response"));
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        logic quiet_ok;
        void'($urandom(32'h5EED_1234));
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1; #1;
        // R11 reset state
        chk("R11 reset valids", {125'd0, req_valid, s_bvalid, s_rvalid}, 128'd0);
        chk("R11 reset awready", {127'd0, s_awready}, 128'd1);

        // R1 R5 directed write, simultaneous AW/W
        drive_write(0, 32'h1000_0040, 32'hDEAD_BEEF, 4'hA);
        serve_req(exp_req(1, 32'h1000_0040, 32'hDEAD_BEEF, 4'hA), 2, "R1 directed write payload");
        send_rsp({1'b1, 2'b01, 32'd0, 1'b0}, 3);
        take_resp(1, 2'b01, 32'd0, 1, "R5 directed BRESP");

        // R2 R6 directed read
        drive_ar(32'h2000_0008);
        serve_req(exp_req(0, 32'h2000_0008, 0, 0), 0, "R2 directed read payload");
        send_rsp({1'b0, 2'b00, 32'hCAFE_F00D, 1'b0}, 10);
        take_resp(0, 2'b00, 32'hCAFE_F00D, 0, "R6 directed RDATA/RRESP");

        // R7 far-side timeout on a read
        drive_ar(32'h2000_000C);
        serve_req(exp_req(0, 32'h2000_000C, 0, 0), 0, "R2 read payload before far timeout");
        send_rsp({1'b0, 2'b00, 32'h1234_5678, 1'b1}, 2);
        take_resp(0, 2'b10, 32'd0, 0, "R7 far timeout read SLVERR zero data");

        // R8 R9 watchdog on a write, exact latency, then stale replies
        drive_write(2, 32'h3000_0000, 32'h0BAD_F00D, 4'hF);
        serve_req(exp_req(1, 32'h3000_0000, 32'h0BAD_F00D, 4'hF), 0, "R1 write payload before timeout");
        n = 1;
        while (!s_bvalid) begin @(negedge clk); #1; n++; end
        chk("R8 timeout latency", 128'(n), 128'(TMO + 1));
        chk("R8 timeout BRESP", {126'd0, s_bresp}, 128'd2);
        send_rsp({1'b1, 2'b01, 32'd0, 1'b0}, 0);
        #1; chk("R9 late reply does not change pending B", {126'd0, s_bresp}, 128'd2);
        @(negedge clk); s_bready = 1; @(posedge clk); @(negedge clk); s_bready = 0;
        send_rsp({1'b0, 2'b00, 32'hFFFF_0000, 1'b0}, 0);
        quiet_ok = 1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); #1;
            if (s_bvalid || s_rvalid || req_valid) quiet_ok = 0;
        end
        chk("R9 stale replies give no beat", {127'd0, quiet_ok}, 128'd1);
        drive_ar(32'h3000_0004);
        serve_req(exp_req(0, 32'h3000_0004, 0, 0), 0, "R2 read after stale replies");
        send_rsp({1'b0, 2'b00, 32'h7777_1111, 1'b0}, 4);
        take_resp(0, 2'b00, 32'h7777_1111, 0, "R9 next read gets its own reply");

        // R12 write wins over simultaneous read
        @(negedge clk);
        s_awvalid = 1; s_awaddr = 32'h4000_0000; s_wvalid = 1; s_wdata = 32'h5555_AAAA; s_wstrb = 4'h3;
        s_arvalid = 1; s_araddr = 32'h4000_0010; #1;
        chk("R12 arready low while write presented", {126'd0, s_arready, s_awready}, 128'd1);
        @(posedge clk); @(negedge clk); s_awvalid = 0; s_wvalid = 0;
        serve_req(exp_req(1, 32'h4000_0000, 32'h5555_AAAA, 4'h3), 0, "R12 write request first");
        send_rsp({1'b1, 2'b11, 32'd0, 1'b0}, 1);
        take_resp(1, 2'b11, 32'd0, 0, "R5 BRESP code 11");
        #1; while (!s_arready) begin @(negedge clk); #1; end
        @(posedge clk); @(negedge clk); s_arvalid = 0;
        serve_req(exp_req(0, 32'h4000_0010, 0, 0), 0, "R12 read request after write");
        send_rsp({1'b0, 2'b01, 32'h0F0F_0F0F, 1'b0}, 0);
        take_resp(0, 2'b01, 32'h0F0F_0F0F, 2, "R6 read after priority write");

        // R3 explicit AW-first order
        drive_write(1, 32'h5000_0000, 32'h1357_9BDF, 4'h1);
        serve_req(exp_req(1, 32'h5000_0000, 32'h1357_9BDF, 4'h1), 1, "R3 AW-first payload");
        send_rsp({1'b1, 2'b00, 32'd0, 1'b1}, 0);
        take_resp(1, 2'b10, 32'd0, 0, "R7 far timeout on write");

        for (int t = 0; t < 60; t++) random_txn();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule